// File: doc/BRIEF.md
# Completion event interrupt generator

This block turns "wait descriptor completed" events from an invalidation engine into interrupt messages. It holds four pieces of state: a completion status flag, an interrupt mask, an interrupt pending flag and a message data register. When a completing wait descriptor carries its interrupt flag, the block sets the status flag. The completion counts as a new interrupt condition only if that flag was clear before. A new condition raises pending. The message then leaves at once or is held until the mask is cleared and the transient busy input drops.

Software reaches the state through a small register port with a synchronous write strobe and a combinational read. The status flag is write-1-to-clear. Clearing it retires a held message without sending it. Messages leave on a valid/ready request port that carries the data value captured at issue time.

Register map (32-bit words):
- Address 0: status, bit 0. Write 1 to clear.
- Address 1: control. Bit 0 is the mask (read/write). Bit 1 is pending (read-only).
- Address 2: message data.
- Address 3 reads zero.

Top module: `cmpl_irq_gen`

## Requirements
- R1: A cycle with `evt_done_i` and `evt_irq_i` both high, while the status flag is clear, sets status (address 0 bit 0) and pending (address 1 bit 1) at that clock edge.
- R2: Such an event while the status flag is already set leaves pending unchanged.
- R3: When pending is set, the mask (address 1 bit 0) is clear and `busy_i` is low, `msg_valid_o` rises one edge later. While the mask is set or `busy_i` is high, no message starts and pending stays set.
- R4: Once raised, `msg_valid_o` and `msg_data_o` hold until an edge with `msg_ready_i` high. Pending clears at that handshake edge.
- R5: Writing 1 to address 0 bit 0 clears status. With no message outstanding, the same write retires pending, and no message follows.
- R6: If status is cleared while a message is outstanding, that message still completes and pending ends clear after the handshake. A new event arriving in that window leaves pending set after the handshake, and a second message follows.
- R7: With both options enabled, the data register at address 2 stores and returns all 32 bits.
- R8: With the extended data option disabled, data bits 31:16 read zero and ignore writes, while bits 15:0 still work.
- R9: With the queued-invalidation option disabled, the data register reads zero and ignores writes.
- R10: After reset, all registers read zero and `msg_valid_o` is low. The mask is read/write, and writes to the pending bit have no effect.
- R11: `msg_data_o` carries the data register value held when the message was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| evt_done_i | input | 1 | Wait descriptor completed this cycle |
| evt_irq_i | input | 1 | Completing descriptor carries the interrupt flag |
| busy_i | input | 1 | Transient condition that holds messages back |
| msg_valid_o | output | 1 | Interrupt message request valid |
| msg_ready_i | input | 1 | Interrupt message accepted |
| msg_data_o | output | 32 | Interrupt message data |

## Verification
The bench builds three copies of the block that share one stimulus: the default with both data options enabled, one with the extended data field disabled, and one with queued invalidation disabled. Each data write in a 32-value sweep is therefore checked against all three masking rules at once. On the full copy, the bench sweeps every combination of mask, busy and prior status around an event. Directed sequences then cover status clears racing an outstanding message and an event re-arming during the handshake window.

// File: rtl/cig_pkg.sv
package cig_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA   = 2'd2;

  function automatic logic [31:0] data_mask(input bit qi_en, input bit ext_en, input int unsigned lo_w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (qi_en && (ext_en || i < int'(lo_w))) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cig_regs.sv
module cig_regs
  import cig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          QI_EN  = 1'b1,
  parameter bit          EXT_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              event_i,
  input  logic              pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              status_o,
  output logic              mask_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sw_clr_o,
  output logic              new_cond_o
);
  localparam int unsigned LO_W = DATA_W / 2;
  localparam logic [31:0] MASK32 = data_mask(QI_EN, EXT_EN, LO_W);
  localparam logic [DATA_W-1:0] DMASK = MASK32[DATA_W-1:0];

  logic              status_q, mask_q;
  logic [DATA_W-1:0] data_q;

  assign sw_clr_o   = we_i && addr_i == A_STATUS && wdata_i[0] && status_q;
  assign new_cond_o = event_i && !status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      mask_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      // set by event wins over software clear
      if (event_i)       status_q <= 1'b1;
      else if (sw_clr_o) status_q <= 1'b0;
      if (we_i && addr_i == A_CTRL) mask_q <= wdata_i[0];
      if (we_i && addr_i == A_DATA) data_q <= wdata_i & DMASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STATUS: rdata_o[0] = status_q;
      A_CTRL: begin
        rdata_o[0] = mask_q;
        rdata_o[1] = pend_i;
      end
      A_DATA:  rdata_o = data_q;
      default: rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign data_o   = data_q;
endmodule

// File: rtl/cig_issue.sv
module cig_issue #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_cond_i,
  input  logic              sw_clr_i,
  input  logic              mask_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_o,
  output logic              rearm_o
);
  logic              pend_q, valid_q, rearm_q;
  logic [DATA_W-1:0] data_q;
  logic              hs, go;

  assign hs = valid_q && ready_i;
  assign go = pend_q && !valid_q && !mask_i && !busy_i && !sw_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      rearm_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (hs)                        pend_q <= new_cond_i || (rearm_q && !sw_clr_i);
      else if (new_cond_i)           pend_q <= 1'b1;
      else if (sw_clr_i && !valid_q) pend_q <= 1'b0;

      // condition arriving while a message is in flight
      rearm_q <= valid_q && !hs && ((rearm_q && !sw_clr_i) || new_cond_i);

      if (valid_q) valid_q <= !ready_i;
      else         valid_q <= go;

      if (go) data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign pend_o  = pend_q;
  assign rearm_o = rearm_q;
endmodule

// File: rtl/cmpl_irq_gen.sv
module cmpl_irq_gen
  import cig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter bit          QI_EN  = 1'b1,
  parameter bit          EXT_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              evt_done_i,
  input  logic              evt_irq_i,
  input  logic              busy_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [DATA_W-1:0] msg_data_o
);
  logic              event_w, status_w, mask_w, sw_clr_w, new_cond_w, pend_w, rearm_w;
  logic [DATA_W-1:0] data_w;

  assign event_w = evt_done_i && evt_irq_i;

  cig_regs #(.DATA_W(DATA_W), .QI_EN(QI_EN), .EXT_EN(EXT_EN)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .event_i(event_w), .pend_i(pend_w),
    .rdata_o(reg_rdata_o), .status_o(status_w), .mask_o(mask_w),
    .data_o(data_w), .sw_clr_o(sw_clr_w), .new_cond_o(new_cond_w)
  );

  cig_issue #(.DATA_W(DATA_W)) u_issue (
    .clk_i, .rst_ni,
    .new_cond_i(new_cond_w), .sw_clr_i(sw_clr_w),
    .mask_i(mask_w), .busy_i(busy_i), .data_i(data_w),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .data_o(msg_data_o),
    .pend_o(pend_w), .rearm_o(rearm_w)
  );
endmodule

// File: rtl/cig_checker.sv
module cig_checker #(
  parameter int unsigned DATA_W = 32,
  parameter bit          QI_EN  = 1'b1,
  parameter bit          EXT_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              event_w,
  input logic              status_w,
  input logic              pend_w,
  input logic              mask_w,
  input logic              sw_clr_w,
  input logic              busy_i,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [DATA_W-1:0] msg_data_o
);
  localparam int unsigned LO_W = DATA_W / 2;

  a_r1_new_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_w && !status_w |=> pend_w && status_w);

  a_r3_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_w && !msg_valid_o |=> !msg_valid_o);

  a_r3_issue_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w && !mask_w && !busy_i && !msg_valid_o && !sw_clr_w |=> msg_valid_o);

  a_r4_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_data_o));

  a_r4_pending_while_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> pend_w);

  a_r5_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_w && !msg_valid_o && !event_w |=> !pend_w && !msg_valid_o);

  a_r8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !EXT_EN |-> msg_data_o[DATA_W-1:LO_W] == '0);

  a_r9_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !QI_EN |-> msg_data_o == '0);
endmodule

bind cmpl_irq_gen cig_checker #(.DATA_W(DATA_W), .QI_EN(QI_EN), .EXT_EN(EXT_EN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .event_w(event_w), .status_w(status_w),
  .pend_w(pend_w), .mask_w(mask_w), .sw_clr_w(sw_clr_w), .busy_i(busy_i),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_data_o(msg_data_o)
);

// File: tb/tb_cmpl_irq_gen.sv
`timescale 1ns/1ps
module tb_cmpl_irq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        ev_done = 1'b0, ev_irq = 1'b0, busy = 1'b0, ready = 1'b0;
  logic [31:0] rd_full, rd_16, rd_noqi, md_full, md_16, md_noqi;
  logic        v_full, v_16, v_noqi;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  cmpl_irq_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_full), .evt_done_i(ev_done), .evt_irq_i(ev_irq), .busy_i(busy),
    .msg_valid_o(v_full), .msg_ready_i(ready), .msg_data_o(md_full));
  cmpl_irq_gen #(.EXT_EN(1'b0)) dut_16 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_16), .evt_done_i(ev_done), .evt_irq_i(ev_irq), .busy_i(busy),
    .msg_valid_o(v_16), .msg_ready_i(ready), .msg_data_o(md_16));
  cmpl_irq_gen #(.QI_EN(1'b0)) dut_noqi (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rd_noqi), .evt_done_i(ev_done), .evt_irq_i(ev_irq), .busy_i(busy),
    .msg_valid_o(v_noqi), .msg_ready_i(ready), .msg_data_o(md_noqi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_full;
  endtask

  task automatic pulse_event(input logic flag);
    ev_done = 1'b1; ev_irq = flag;
    tick();
    ev_done = 1'b0; ev_irq = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; busy = 1'b0; ready = 1'b0; we = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  function automatic logic [31:0] pend_bit(input logic [31:0] r);
    return {31'd0, r[1]};
  endfunction

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, val, dval;
    do_reset();
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R10 reset rdata", r, 32'd0);
    end
    chk("R10 reset valid", {31'd0, v_full}, 32'd0);
    wr(2'd1, 32'h3);
    rd(2'd1, r);
    chk("R10 mask rw, pending ro", r, 32'h1);
    wr(2'd1, 32'h0);
    rd(2'd1, r);
    chk("R10 mask cleared", r, 32'h0);

    // event without interrupt flag is not an interrupt condition
    pulse_event(1'b0);
    rd(2'd0, r);
    chk("R1 no flag no status", r, 32'd0);

    // R7 R8 R9 data sweep over three configurations
    for (int i = 0; i < 32; i++) begin
      val = (32'(i) * 32'h9E3779B1) ^ (32'h1 << i);
      wr(2'd2, val);
      addr = 2'd2; #1;
      chk("R7 data full", rd_full, val);
      chk("R8 data ext off", rd_16, val & 32'h0000_FFFF);
      chk("R9 data qi off", rd_noqi, 32'd0);
    end

    // R1..R4, R11 sweep over mask, busy, prior status
    for (int c = 0; c < 8; c++) begin
      logic m, b, s, exp_v;
      m = c[0]; b = c[1]; s = c[2];
      do_reset();
      dval = 32'hA5C3_1E70 + 32'(c);
      wr(2'd2, dval);
      if (s) begin
        ready = 1'b1;
        wr(2'd1, 32'h1);
        pulse_event(1'b1);
        wr(2'd1, 32'h0);
        tick(); tick();
        ready = 1'b0;
        rd(2'd1, r);
        chk("R4 preset pending drained", pend_bit(r), 32'd0);
      end
      wr(2'd1, {31'd0, m});
      busy = b;
      pulse_event(1'b1);
      rd(2'd0, r);
      chk("R1 status set", r, 32'd1);
      rd(2'd1, r);
      chk(s ? "R2 no new condition" : "R1 pending set", pend_bit(r), {31'd0, !s});
      tick();
      exp_v = !s && !m && !b;
      chk("R3 issue decision", {31'd0, v_full}, {31'd0, exp_v});
      tick(); tick();
      chk("R4 valid held", {31'd0, v_full}, {31'd0, exp_v});
      rd(2'd1, r);
      chk("R3 pending held", pend_bit(r), {31'd0, !s});
      busy = 1'b0;
      wr(2'd1, 32'h0);
      tick();
      chk("R3 issue after release", {31'd0, v_full}, {31'd0, !s});
      if (!s) chk("R11 message data", md_full, dval);
      ready = 1'b1;
      tick();
      ready = 1'b0;
      chk("R4 valid drops at handshake", {31'd0, v_full}, 32'd0);
      rd(2'd1, r);
      chk("R4 pending clears at handshake", pend_bit(r), 32'd0);
    end

    // R5 retire without message
    do_reset();
    wr(2'd1, 32'h1);
    pulse_event(1'b1);
    wr(2'd0, 32'h1);
    rd(2'd0, r);
    chk("R5 status cleared", r, 32'd0);
    rd(2'd1, r);
    chk("R5 pending retired", pend_bit(r), 32'd0);
    wr(2'd1, 32'h0);
    tick(); tick();
    chk("R5 no message", {31'd0, v_full}, 32'd0);

    // R6 clear while message outstanding
    do_reset();
    pulse_event(1'b1);
    tick();
    chk("R6 message out", {31'd0, v_full}, 32'd1);
    wr(2'd0, 32'h1);
    rd(2'd1, r);
    chk("R6 pending kept while out", pend_bit(r), 32'd1);
    chk("R6 valid kept", {31'd0, v_full}, 32'd1);
    ready = 1'b1;
    tick();
    ready = 1'b0;
    rd(2'd1, r);
    chk("R6 pending clear after handshake", pend_bit(r), 32'd0);
    tick();
    chk("R6 no second message", {31'd0, v_full}, 32'd0);

    // R6 re-arm: clear status, new event, then handshake
    do_reset();
    pulse_event(1'b1);
    tick();
    wr(2'd0, 32'h1);
    pulse_event(1'b1);
    ready = 1'b1;
    tick();
    ready = 1'b0;
    rd(2'd1, r);
    chk("R6 rearm pending", pend_bit(r), 32'd1);
    tick();
    chk("R6 second message", {31'd0, v_full}, 32'd1);
    ready = 1'b1;
    tick();
    ready = 1'b0;
    rd(2'd1, r);
    chk("R6 second handshake clears", pend_bit(r), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule